// File: doc/BRIEF.md
# Address-Decoded Serial Register Loader

This block is the programming port of a dual synthesizer. A host drives three wires: a serial clock, a serial data line and a latch enable. Each frame is 18 bits, most significant bit first. The first sixteen bits are a payload. The final two bits pick the destination. When latch enable goes high, the payload is copied into one of four configuration latches. The four latches are the auxiliary and main reference dividers and the auxiliary and main feedback dividers.

All three wires are synchronized into the system clock domain. The edges of the serial clock and of latch enable are found there. The port has no power-state input, so it accepts frames at all times.

The auxiliary reference latch is also presented as two decoded fields: a 4-bit output-mux select and a 12-bit reference divide ratio. A reference divide ratio below 2 is illegal. Such a load into either reference latch is refused, and a one-cycle error flag is raised.

Top module: `cfg_serial_loader`

## Requirements
- R1: After reset, all four latches, both decoded fields and the error flag are zero.
- R2: Bits are taken on rising serial clock edges, most significant first. The frame is {payload[15:0], dest[1:0]}, so dest is the last two bits clocked in.
- R3: dest 2'b00 at a latch-enable rising edge loads the payload into the auxiliary reference latch.
- R4: dest 2'b01 loads the auxiliary feedback latch.
- R5: dest 2'b10 loads the main reference latch.
- R6: dest 2'b11 loads the main feedback latch.
- R7: A load changes at most one latch. The other three keep their contents.
- R8: The mux select output equals bits 15:12 of the auxiliary reference latch. The divide-ratio output equals bits 11:0 of that latch.
- R9: A load to either reference latch whose payload bits 11:0 are 0 or 1 is refused. The latch keeps its old value, and the error flag is high for exactly one system clock cycle.
- R10: The feedback latches accept any payload, including zero, and never raise the error flag.
- R11: If more than 18 bits are shifted before latch enable, only the last 18 are used.
- R12: Shifting bits without a latch-enable rising edge leaves all latches unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat_i | input | 1 | Serial data, most significant bit first |
| ser_le_i | input | 1 | Latch enable; its rising edge commits the frame |
| aux_r_o | output | 16 | Auxiliary reference latch |
| aux_n_o | output | 16 | Auxiliary feedback latch |
| main_r_o | output | 16 | Main reference latch |
| main_n_o | output | 16 | Main feedback latch |
| aux_sel_o | output | 4 | Output-mux select field of the auxiliary reference latch |
| aux_ratio_o | output | 12 | Reference divide ratio field of the auxiliary reference latch |
| err_o | output | 1 | One-cycle pulse when a reference load is refused |

## Verification
The loader is driven with frames for each of the four destinations. The payloads use distinct, asymmetric bit patterns, so a reversed bit order or a swapped destination decode shows up as a wrong latch or a mirrored value.

Reference loads with ratios 0, 1 and 2 separate the refusal boundary from the first legal value. A zero payload into a feedback latch shows that the ratio check is not applied there.

A frame with two junk leading bits checks that only the last 18 bits count. A frame shifted with no latch-enable pulse checks that nothing is loaded without that edge.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
    localparam int PAYLOAD_W = 16;
    localparam int DEST_W    = 2;
    localparam int FRAME_W   = PAYLOAD_W + DEST_W;
    localparam int RATIO_W   = 12;
    localparam int SEL_W     = PAYLOAD_W - RATIO_W;
    localparam int NUM_DEST  = 1 << DEST_W;
    localparam int MIN_RATIO = 2;

    typedef enum logic [DEST_W-1:0] {
        DEST_AUX_REF  = 2'b00,
        DEST_AUX_FB   = 2'b01,
        DEST_MAIN_REF = 2'b10,
        DEST_MAIN_FB  = 2'b11
    } dest_e;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.pipe[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.pipe[i] = st_q.pipe[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.pipe[STAGES-1];
endmodule

// File: rtl/cfg_rise.sv
module cfg_rise (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic rise_o
);
    typedef struct packed {
        logic prev;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.prev = lvl_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise_o = lvl_i & ~st_q.prev;
endmodule

// File: rtl/cfg_shift.sv
module cfg_shift #(
    parameter int FRAME_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               take_i,
    input  logic               bit_i,
    output logic [FRAME_W-1:0] frame_o
);
    typedef struct packed {
        logic [FRAME_W-1:0] sr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (take_i) begin
            st_d.sr = {st_q.sr[FRAME_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign frame_o = st_q.sr;
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
    import cfg_loader_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load_i,
    input  logic [FRAME_W-1:0]                  frame_i,
    output logic [NUM_DEST-1:0][PAYLOAD_W-1:0]  regs_o,
    output logic                                err_o
);
    typedef struct packed {
        logic [NUM_DEST-1:0][PAYLOAD_W-1:0] regs;
        logic                               err;
    } state_t;

    state_t st_d, st_q;

    logic [PAYLOAD_W-1:0] payload;
    dest_e                dest;
    logic                 is_ref;
    logic                 ratio_bad;

    assign payload   = frame_i[FRAME_W-1:DEST_W];
    assign dest      = dest_e'(frame_i[DEST_W-1:0]);
    assign is_ref    = (dest == DEST_AUX_REF) || (dest == DEST_MAIN_REF);
    assign ratio_bad = payload[RATIO_W-1:0] < RATIO_W'(MIN_RATIO);

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (load_i) begin
            if (is_ref && ratio_bad) begin
                st_d.err = 1'b1;
            end else begin
                for (int i = 0; i < NUM_DEST; i++) begin
                    if (DEST_W'(i) == dest) st_d.regs[i] = payload;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign regs_o = st_q.regs;
    assign err_o  = st_q.err;
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
    import cfg_loader_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk_i,
    input  logic                 ser_dat_i,
    input  logic                 ser_le_i,
    output logic [PAYLOAD_W-1:0] aux_r_o,
    output logic [PAYLOAD_W-1:0] aux_n_o,
    output logic [PAYLOAD_W-1:0] main_r_o,
    output logic [PAYLOAD_W-1:0] main_n_o,
    output logic [SEL_W-1:0]     aux_sel_o,
    output logic [RATIO_W-1:0]   aux_ratio_o,
    output logic                 err_o
);
    logic [2:0]                         wires_s;
    logic                               sclk_rise;
    logic                               load_stb;
    logic [FRAME_W-1:0]                 frame;
    logic [NUM_DEST-1:0][PAYLOAD_W-1:0] regs;

    cfg_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_le_i, ser_dat_i, ser_clk_i}),
        .sync_o  (wires_s)
    );

    cfg_rise u_sclk_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (wires_s[0]),
        .rise_o (sclk_rise)
    );

    cfg_rise u_le_rise (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (wires_s[2]),
        .rise_o (load_stb)
    );

    cfg_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .take_i  (sclk_rise),
        .bit_i   (wires_s[1]),
        .frame_o (frame)
    );

    cfg_bank u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_stb),
        .frame_i (frame),
        .regs_o  (regs),
        .err_o   (err_o)
    );

    assign aux_r_o     = regs[DEST_AUX_REF];
    assign aux_n_o     = regs[DEST_AUX_FB];
    assign main_r_o    = regs[DEST_MAIN_REF];
    assign main_n_o    = regs[DEST_MAIN_FB];
    assign aux_sel_o   = aux_r_o[PAYLOAD_W-1:RATIO_W];
    assign aux_ratio_o = aux_r_o[RATIO_W-1:0];
endmodule

// File: rtl/cfg_serial_loader_chk.sv
module cfg_serial_loader_chk
    import cfg_loader_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 load_stb,
    input logic [PAYLOAD_W-1:0] aux_r_o,
    input logic [PAYLOAD_W-1:0] aux_n_o,
    input logic [PAYLOAD_W-1:0] main_r_o,
    input logic [PAYLOAD_W-1:0] main_n_o,
    input logic                 err_o
);
    a_r9_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    a_r9_refused_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> ($stable(aux_r_o) && $stable(main_r_o)));

    a_r9_aux_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (aux_r_o != $past(aux_r_o)) |-> (aux_r_o[RATIO_W-1:0] >= RATIO_W'(MIN_RATIO)));

    a_r9_main_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (main_r_o != $past(main_r_o)) |-> (main_r_o[RATIO_W-1:0] >= RATIO_W'(MIN_RATIO)));

    a_r7_one_latch: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({aux_r_o != $past(aux_r_o), aux_n_o != $past(aux_n_o),
                  main_r_o != $past(main_r_o), main_n_o != $past(main_n_o)}));

    a_r12_no_load_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> ($stable(aux_r_o) && $stable(aux_n_o) &&
                       $stable(main_r_o) && $stable(main_n_o) && !err_o));
endmodule

bind cfg_serial_loader cfg_serial_loader_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_stb (load_stb),
    .aux_r_o  (aux_r_o),
    .aux_n_o  (aux_n_o),
    .main_r_o (main_r_o),
    .main_n_o (main_n_o),
    .err_o    (err_o)
);

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, sle = 1'b0;
    logic [15:0] aux_r, aux_n, main_r, main_n;
    logic [3:0]  aux_sel;
    logic [11:0] aux_ratio;
    logic        err;

    int checks = 0;
    int errors = 0;
    int err_pulses = 0;
    bit done = 0;

    typedef struct {
        logic [15:0] regs [4];
        int          pulses;
        string       tag;
    } item_t;

    item_t q [$];
    logic [15:0] model [4];
    int exp_pulses = 0;

    always #10 clk = ~clk;

    cfg_serial_loader u_dut (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_le_i(sle),
        .aux_r_o(aux_r), .aux_n_o(aux_n), .main_r_o(main_r), .main_n_o(main_n),
        .aux_sel_o(aux_sel), .aux_ratio_o(aux_ratio), .err_o(err)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n && err === 1'b1) err_pulses++;

    task automatic wait_clk(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic shift_bit(logic b);
        sdat = b;
        wait_clk(4);
        sclk = 1'b1;
        wait_clk(4);
        sclk = 1'b0;
    endtask

    task automatic push(string tag);
        item_t it;
        for (int i = 0; i < 4; i++) it.regs[i] = model[i];
        it.pulses = exp_pulses;
        it.tag = tag;
        q.push_back(it);
        wait_clk(14);
    endtask

    task automatic send(logic [15:0] data, logic [1:0] dest, string tag, bit junk = 0, bit do_le = 1);
        logic [17:0] fr = {data, dest};
        if (junk) begin
            shift_bit(1'b1);
            shift_bit(1'b0);
        end
        for (int i = 17; i >= 0; i--) shift_bit(fr[i]);
        if (do_le) begin
            sle = 1'b1;
            wait_clk(4);
            sle = 1'b0;
            if ((dest == 2'b00 || dest == 2'b10) && data[11:0] < 12'd2) exp_pulses++;
            else model[dest] = data;
        end
        push(tag);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            wait (q.size() > 0);
            it = q.pop_front();
            wait_clk(2);
            chk({it.tag, " aux_r"},  aux_r,  it.regs[0]);
            chk({it.tag, " aux_n"},  aux_n,  it.regs[1]);
            chk({it.tag, " main_r"}, main_r, it.regs[2]);
            chk({it.tag, " main_n"}, main_n, it.regs[3]);
            chk({it.tag, " R8 sel"},   aux_sel,   it.regs[0][15:12]);
            chk({it.tag, " R8 ratio"}, aux_ratio, it.regs[0][11:0]);
            chk({it.tag, " R9 err pulses"}, err_pulses, it.pulses);
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        for (int i = 0; i < 4; i++) model[i] = '0;
        wait_clk(3);
        // R1: reset state
        chk("R1 aux_r", aux_r, 0);
        chk("R1 aux_n", aux_n, 0);
        chk("R1 main_r", main_r, 0);
        chk("R1 main_n", main_n, 0);
        chk("R1 err", err, 0);
        rst_n = 1'b1;
        wait_clk(3);
        send(16'hA5C3, 2'b00, "R2 R3 aux ref");
        send(16'h1234, 2'b01, "R4 aux fb");
        send(16'h8E07, 2'b10, "R5 main ref");
        send(16'hF00D, 2'b11, "R6 main fb");
        send(16'h7FF2, 2'b01, "R7 one latch");
        send(16'h3001, 2'b00, "R9 aux ratio 1");
        send(16'hC000, 2'b10, "R9 main ratio 0");
        send(16'h6002, 2'b10, "R9 main ratio 2");
        send(16'h0000, 2'b11, "R10 zero fb");
        send(16'h0001, 2'b01, "R10 one fb");
        send(16'h9ABC, 2'b00, "R11 junk lead", 1);
        send(16'h5555, 2'b11, "R12 no le", 0, 0);
        wait (q.size() == 0);
        wait_clk(10);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule